// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and a calendar in packed BCD digits. A clock enable at 32.768 kHz drives a binary prescaler. Each time the prescaler wraps, the block produces a once-per-second step. That step ripples through seconds, minutes, hours, a weekday code, the day of the month, the month and a two-digit year. A two-bit leap counter decides whether February has 28 or 29 days. Hours count either 0–23 or 1–12, and in 12-hour form an AM/PM flag is carried inside the tens-of-hours digit.

A host reaches the block through a plain 4-bit register port. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `addr`. There is no back-pressure: every write is accepted in the cycle it is presented, and `rd_data` is valid in the same cycle as `addr`.

The control register has four bits:
- A stop level and a wait level, either of which freezes the counters. A second that falls due while frozen is held and applied on release.
- A prescaler-clear pulse.
- A round-to-minute adjust pulse.

A configuration register chooses three things: whether clears affect the whole prescaler or only its upper six stages, whether leap handling is on, and which hour format is used. `busy` warns the host that a seconds update is imminent, or that an adjust carry is still in flight.

Top module: `cal_clock`

## Requirements
- R1: After reset, every digit reads 0 except 1-day (addr 0x7) and 1-month (addr 0x9), which read 1. The leap counter (0xF), configuration (0xE) and `busy` read 0, and the block runs in 24-hour mode.
- R2: The digit address map is as follows:
  - 0x0 seconds ones, 0x1 seconds tens
  - 0x2 minutes ones, 0x3 minutes tens
  - 0x4 hours ones, 0x5 hours tens
  - 0x6 weekday
  - 0x7 day ones, 0x8 day tens
  - 0x9 month ones, 0xA month tens
  - 0xB year ones, 0xC year tens

  One second passes per 2^DIV_BITS enabled clocks. Seconds count 00–59 in BCD, and wrapping from 59 carries into minutes (00–59), which carry into hours.
- R3: In 24-hour mode, hours run 00–23. Passing 23 → 00 advances the day, and the weekday code cycles 0..6 then back to 0.
- R4: When configuration bit 2 is 1, the block is in 12-hour mode. Hours run 1–12, with bits 1:0 of the tens digit holding the tens value and bit 2 holding PM (1) or AM (0). Hour 11 → 12 toggles PM, so 11 AM → 0x52 and 11 PM → 0x12. Going from 11 PM to 12 AM advances the day. Hour 12 → 1 keeps the flag.
- R5: Months 4, 6, 9 and 11 end after day 30, and the other months except February end after day 31. The day then returns to 01 and the month advances. December rolls to January and advances the year, and year 99 rolls to 00.
- R6: February ends after day 29 when leap handling is on (configuration bit 1 = 0) and the leap counter is 0. Otherwise February ends after day 28.
- R7: The leap counter reads at 0xF in bits 1:0 and is written directly there. Writing either year digit reloads it with the year value modulo 4. It increments, wrapping, each time the year advances.
- R8: Writing 0xD with bit 1 set is the adjust command:
  - It clears the seconds.
  - If seconds were 30–59, one minute is added on the next clock. That minute ripples through every higher digit, and `busy` is 1 for the cycle in between.
  - If seconds were 00–29, the minutes are left unchanged.
- R9: Writing 0xD with bit 0 or bit 1 set clears the prescaler. With configuration bit 0 = 1 every stage is cleared. With it at 0, only stages at position KEEP_LSB and above are cleared, and the lower stages are kept.
- R10: 0xD bit 2 (stop) and bit 3 (wait) are levels. While either is 1, no digit advances, and one second falling due is held. Clearing both applies it on the next clock. The prescaler keeps running, so the following second arrives on its normal schedule.
- R11: `busy` is 1 during the last BUSY_LEAD prescaler counts before each seconds update, and 0 otherwise except during an adjust carry.
- R12: Configuration reads back at 0xE in bits 2:0. Reading 0xD returns wait in bit 3, stop in bit 2 and `busy` in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_32k | input | 1 | 32.768 kHz clock enable for the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Read data for `addr`, combinational |
| busy | output | 1 | Seconds update imminent or adjust carry pending |

## Verification
A register write lands on the edge where `wr_en` is sampled, so the bench reads the result at the following falling edge. The adjust command clears the seconds at its own edge and adds the rounded minute one edge later, and the bench samples at both of those points. A cleared prescaler produces the next second exactly 2^DIV_BITS edges after a full clear. After a partial clear it takes correspondingly fewer edges, set by the low bits that were kept, and the bench counts edges from the clear to read the seconds one edge before and at the expected step. A held second is applied one edge after the release write, and `busy` rises BUSY_LEAD edges before the step; both are checked at those exact edges.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NDIG = 13;
  localparam int D_S1  = 0;
  localparam int D_S10 = 1;
  localparam int D_M1  = 2;
  localparam int D_M10 = 3;
  localparam int D_H1  = 4;
  localparam int D_H10 = 5;
  localparam int D_WD  = 6;
  localparam int D_D1  = 7;
  localparam int D_D10 = 8;
  localparam int D_MO1 = 9;
  localparam int D_MO10 = 10;
  localparam int D_Y1  = 11;
  localparam int D_Y10 = 12;
  localparam logic [3:0] A_CTRL = 4'hD;
  localparam logic [3:0] A_CFG  = 4'hE;
  localparam logic [3:0] A_LEAP = 4'hF;

  typedef logic [NDIG-1:0][3:0] digits_t;

  function automatic logic [6:0] bcd_val(input logic [3:0] t, input logic [3:0] o);
    return 7'(({3'b000, t} * 7'd10) + {3'b000, o});
  endfunction

  function automatic logic [3:0] tens_of(input logic [6:0] v);
    return 4'(v / 7'd10);
  endfunction

  function automatic logic [3:0] ones_of(input logic [6:0] v);
    return 4'(v % 7'd10);
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic leap_ok);
    case (m)
      7'd2:                    return leap_ok ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                 return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV_BITS  = 15,
  parameter int KEEP_LSB  = 9,
  parameter int BUSY_LEAD = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic clr,
  input  logic clr_all,
  output logic one_hz,
  output logic near_top
);
  localparam logic [DIV_BITS-1:0] MAXV      = '1;
  localparam logic [DIV_BITS-1:0] KEEP_MASK = MAXV >> (DIV_BITS - KEEP_LSB);
  localparam logic [DIV_BITS-1:0] BUSY_FROM = MAXV - DIV_BITS'(BUSY_LEAD - 1);

  logic [DIV_BITS-1:0] cnt;

  assign one_hz   = ce && (cnt == MAXV) && !clr;
  assign near_top = (cnt >= BUSY_FROM);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= clr_all ? '0 : (cnt & KEEP_MASK);
    else if (ce)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cal_time_next.sv
module cal_time_next
  import cal_pkg::*;
(
  input  digits_t    dig_i,
  input  logic [1:0] leap_i,
  input  logic       step_sec,
  input  logic       step_min,
  input  logic       h12,
  input  logic       leap_off,
  output digits_t    dig_o,
  output logic [1:0] leap_o,
  output logic       yr_step
);
  logic [6:0] sv, mv, hv, dv, mov, yv, mlen;
  logic [3:0] ht;
  logic       c_min, c_hr, c_day, c_mon, c_yr, pm;

  always_comb begin
    sv   = bcd_val(dig_i[D_S10], dig_i[D_S1]);
    mv   = bcd_val(dig_i[D_M10], dig_i[D_M1]);
    hv   = h12 ? bcd_val({2'b00, dig_i[D_H10][1:0]}, dig_i[D_H1])
               : bcd_val(dig_i[D_H10], dig_i[D_H1]);
    pm   = dig_i[D_H10][2];
    dv   = bcd_val(dig_i[D_D10], dig_i[D_D1]);
    mov  = bcd_val(dig_i[D_MO10], dig_i[D_MO1]);
    yv   = bcd_val(dig_i[D_Y10], dig_i[D_Y1]);
    mlen = month_len(mov, !leap_off && (leap_i == 2'b00));
    dig_o  = dig_i;
    leap_o = leap_i;
    c_min = step_min;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;

    if (step_sec) begin
      if (sv >= 7'd59) begin sv = 7'd0; c_min = 1'b1; end
      else sv = sv + 7'd1;
    end
    if (c_min) begin
      if (mv >= 7'd59) begin mv = 7'd0; c_hr = 1'b1; end
      else mv = mv + 7'd1;
    end
    if (c_hr) begin
      if (h12) begin
        if (hv == 7'd11) begin hv = 7'd12; c_day = pm; pm = ~pm; end
        else if (hv >= 7'd12) hv = 7'd1;
        else hv = hv + 7'd1;
      end else begin
        if (hv >= 7'd23) begin hv = 7'd0; c_day = 1'b1; end
        else hv = hv + 7'd1;
      end
    end
    if (c_day) begin
      dig_o[D_WD] = (dig_i[D_WD] >= 4'd6) ? 4'd0 : dig_i[D_WD] + 4'd1;
      if (dv >= mlen) begin dv = 7'd1; c_mon = 1'b1; end
      else dv = dv + 7'd1;
    end
    if (c_mon) begin
      if (mov >= 7'd12) begin mov = 7'd1; c_yr = 1'b1; end
      else mov = mov + 7'd1;
    end
    if (c_yr) begin
      yv     = (yv >= 7'd99) ? 7'd0 : yv + 7'd1;
      leap_o = leap_i + 2'd1;
    end

    ht = tens_of(hv);
    dig_o[D_S1]   = ones_of(sv);
    dig_o[D_S10]  = tens_of(sv);
    dig_o[D_M1]   = ones_of(mv);
    dig_o[D_M10]  = tens_of(mv);
    dig_o[D_H1]   = ones_of(hv);
    dig_o[D_H10]  = h12 ? {1'b0, pm, ht[1:0]} : ht;
    dig_o[D_D1]   = ones_of(dv);
    dig_o[D_D10]  = tens_of(dv);
    dig_o[D_MO1]  = ones_of(mov);
    dig_o[D_MO10] = tens_of(mov);
    dig_o[D_Y1]   = ones_of(yv);
    dig_o[D_Y10]  = tens_of(yv);
    yr_step = c_yr;
  end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int DIV_BITS  = 15,
  parameter int KEEP_LSB  = 9,
  parameter int BUSY_LEAD = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_32k,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data,
  output logic       busy
);
  digits_t    dig, dig_nx, dig_n;
  logic [1:0] leap, leap_nx, leap_n;
  logic [2:0] cfg;
  logic       stop_q, wait_q, tick_pend, adj_pend;
  logic       wr_ctrl, cmd_clr, cmd_adj, hold, one_hz, near_top, step_sec, yr_step;
  logic [6:0] yr_new;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign cmd_clr  = wr_ctrl && wr_data[0];
  assign cmd_adj  = wr_ctrl && wr_data[1];
  assign hold     = stop_q || wait_q;
  assign step_sec = !hold && (one_hz || tick_pend);
  assign busy     = near_top || adj_pend;

  cal_prescaler #(.DIV_BITS(DIV_BITS), .KEEP_LSB(KEEP_LSB), .BUSY_LEAD(BUSY_LEAD)) u_div (
    .clk(clk), .rst_n(rst_n), .ce(ce_32k), .clr(cmd_clr || cmd_adj),
    .clr_all(cfg[0]), .one_hz(one_hz), .near_top(near_top)
  );

  cal_time_next u_next (
    .dig_i(dig), .leap_i(leap), .step_sec(step_sec), .step_min(adj_pend),
    .h12(cfg[2]), .leap_off(cfg[1]), .dig_o(dig_nx), .leap_o(leap_nx), .yr_step(yr_step)
  );

  always_comb begin
    dig_n  = dig_nx;
    leap_n = leap_nx;
    if (cmd_adj) begin
      dig_n[D_S1]  = 4'd0;
      dig_n[D_S10] = 4'd0;
    end
    if (wr_en && (addr <= 4'd12)) dig_n[addr] = wr_data;
    yr_new = bcd_val(dig_n[D_Y10], dig_n[D_Y1]);
    if (wr_en && ((addr == 4'd11) || (addr == 4'd12))) leap_n = yr_new[1:0];
    if (wr_en && (addr == A_LEAP)) leap_n = wr_data[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig          <= '0;
      dig[D_D1]    <= 4'd1;
      dig[D_MO1]   <= 4'd1;
      leap         <= 2'd0;
      cfg          <= 3'd0;
      stop_q       <= 1'b0;
      wait_q       <= 1'b0;
      tick_pend    <= 1'b0;
      adj_pend     <= 1'b0;
    end else begin
      dig      <= dig_n;
      leap     <= leap_n;
      adj_pend <= cmd_adj && (bcd_val(dig[D_S10], dig[D_S1]) >= 7'd30);
      if (wr_en && (addr == A_CFG)) cfg <= wr_data[2:0];
      if (wr_ctrl) begin
        stop_q <= wr_data[2];
        wait_q <= wr_data[3];
      end
      if (cmd_clr || cmd_adj)   tick_pend <= 1'b0;
      else if (hold && one_hz)  tick_pend <= 1'b1;
      else if (!hold)           tick_pend <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {wait_q, stop_q, busy, 1'b0};
      A_CFG:   rd_data = {1'b0, cfg};
      A_LEAP:  rd_data = {2'b00, leap};
      default: rd_data = dig[addr];
    endcase
  end
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       cmd_adj,
  input logic       busy,
  input logic       one_hz,
  input logic       hold,
  input logic       step_sec,
  input logic       yr_step,
  input logic [1:0] leap,
  input logic [3:0] sec_o,
  input logic [3:0] sec_t,
  input logic [3:0] wday
);
  AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_sec && !wr_en && sec_o <= 4'd9 && sec_t <= 4'd5) |=> (sec_o <= 4'd9 && sec_t <= 4'd5)); // R2
  AST_WDAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && wday <= 4'd6) |=> (wday <= 4'd6)); // R3
  AST_LEAP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (yr_step && !wr_en) |=> (leap == $past(leap) + 2'd1)); // R7
  AST_ADJ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_adj |=> (sec_o == 4'd0 && sec_t == 4'd0)); // R8
  AST_ADJ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_adj && sec_t >= 4'd3 && sec_t <= 4'd5) |=> busy); // R8
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> ($stable(sec_o) && $stable(sec_t))); // R10
  AST_BUSY_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    one_hz |-> busy); // R11
endmodule

bind cal_clock cal_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_adj(cmd_adj), .busy(busy),
  .one_hz(one_hz), .hold(hold), .step_sec(step_sec), .yr_step(yr_step), .leap(leap),
  .sec_o(dig[0]), .sec_t(dig[1]), .wday(dig[6])
);

// File: tb/cal_clock_tb.sv
module cal_clock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_32k = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] rd_data;
  logic       busy;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_clock #(.DIV_BITS(8), .KEEP_LSB(2), .BUSY_LEAD(15)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_32k(ce_32k), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
  );

  // fields: cfg, leap write (F = none), start, expected after one second, requirement
  // time packing: yr mon day wday hr min sec, each two hex digits
  typedef struct packed {
    logic [3:0]  cfg;
    logic [3:0]  leapw;
    logic [55:0] start;
    logic [55:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 4'hF, 56'h00010100000008, 56'h00010100000009, 8'd2},  // R2
    '{4'h0, 4'hF, 56'h00010100123459, 56'h00010100123500, 8'd2},  // R2
    '{4'h0, 4'hF, 56'h00010100105959, 56'h00010100110000, 8'd2},  // R2
    '{4'h0, 4'hF, 56'h24031506235959, 56'h24031600000000, 8'd3},  // R3
    '{4'h4, 4'hF, 56'h24031502115959, 56'h24031502520000, 8'd4},  // R4
    '{4'h4, 4'hF, 56'h24031502525959, 56'h24031502410000, 8'd4},  // R4
    '{4'h4, 4'hF, 56'h24030502515959, 56'h24030603120000, 8'd4},  // R4
    '{4'h0, 4'hF, 56'h24043001235959, 56'h24050102000000, 8'd5},  // R5
    '{4'h0, 4'hF, 56'h99123104235959, 56'h00010105000000, 8'd5},  // R5
    '{4'h0, 4'hF, 56'h24022800235959, 56'h24022901000000, 8'd6},  // R6
    '{4'h0, 4'hF, 56'h23022800235959, 56'h23030101000000, 8'd6},  // R6
    '{4'h0, 4'hF, 56'h24022903235959, 56'h24030104000000, 8'd6},  // R6
    '{4'h2, 4'hF, 56'h24022800235959, 56'h24030101000000, 8'd6},  // R6
    '{4'h0, 4'h0, 56'h23022800235959, 56'h23022901000000, 8'd7},  // R7
    '{4'h0, 4'hF, 56'h24013100235959, 56'h24020101000000, 8'd5},  // R5
    '{4'h0, 4'hF, 56'h24063005235959, 56'h24070106000000, 8'd5}   // R5
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic load_time(input logic [55:0] t);
    wr(4'hB, t[51:48]); wr(4'hC, t[55:52]);
    wr(4'h9, t[43:40]); wr(4'hA, t[47:44]);
    wr(4'h7, t[35:32]); wr(4'h8, t[39:36]);
    wr(4'h6, t[27:24]);
    wr(4'h4, t[19:16]); wr(4'h5, t[23:20]);
    wr(4'h2, t[11:8]);  wr(4'h3, t[15:12]);
    wr(4'h0, t[3:0]);   wr(4'h1, t[7:4]);
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [3:0] v;
    t = '0;
    rd(4'hC, v); t[55:52] = v; rd(4'hB, v); t[51:48] = v;
    rd(4'hA, v); t[47:44] = v; rd(4'h9, v); t[43:40] = v;
    rd(4'h8, v); t[39:36] = v; rd(4'h7, v); t[35:32] = v;
    rd(4'h6, v); t[27:24] = v;
    rd(4'h5, v); t[23:20] = v; rd(4'h4, v); t[19:16] = v;
    rd(4'h3, v); t[15:12] = v; rd(4'h2, v); t[11:8] = v;
    rd(4'h1, v); t[7:4] = v;   rd(4'h0, v); t[3:0] = v;
  endtask

  task automatic read_sec(output logic [7:0] s);
    logic [3:0] v;
    rd(4'h1, v); s[7:4] = v;
    rd(4'h0, v); s[3:0] = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [3:0]  v;
    logic [7:0]  s;
    logic [55:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    read_time(t);
    check(t == 56'h00010100000000, "R1 time", 64'(t), 64'h00010100000000);
    rd(A_LEAP_ADDR(), v); check(v == 4'h0, "R1 leap", 64'(v), 64'h0);
    rd(4'hE, v); check(v == 4'h0, "R1 cfg", 64'(v), 64'h0);
    check(busy == 1'b0, "R1 busy", 64'(busy), 64'h0);

    // table of one-second steps
    for (int i = 0; i < NVEC; i++) begin
      wr(4'hD, 4'h4);
      wr(4'hE, VECS[i].cfg);
      load_time(VECS[i].start);
      if (VECS[i].leapw != 4'hF) wr(4'hF, VECS[i].leapw);
      wr(4'hD, 4'h1);
      repeat (300) @(negedge clk);
      read_time(t);
      n_chk++;
      if (t != VECS[i].expv) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", VECS[i].req, i, t, VECS[i].expv);
      end
    end

    // R7: leap counter reload, direct write, year advance
    wr(4'hD, 4'h4); wr(4'hE, 4'h0);
    load_time(56'h23123100235959);
    rd(4'hF, v); check(v == 4'h3, "R7 reload", 64'(v), 64'h3);
    wr(4'hF, 4'h1);
    rd(4'hF, v); check(v == 4'h1, "R7 direct", 64'(v), 64'h1);
    wr(4'hC, 4'h2);
    rd(4'hF, v); check(v == 4'h3, "R7 rewrite year", 64'(v), 64'h3);
    wr(4'hD, 4'h1);
    repeat (300) @(negedge clk);
    rd(4'hF, v); check(v == 4'h0, "R7 year step", 64'(v), 64'h0);

    // R8: adjust rounding up with ripple to hours
    wr(4'hD, 4'h4);
    load_time(56'h24031502105945);
    wr(4'hD, 4'h6);
    check(busy == 1'b1, "R8 busy in carry", 64'(busy), 64'h1);
    read_sec(s); check(s == 8'h00, "R8 sec cleared", 64'(s), 64'h00);
    @(negedge clk);
    read_time(t);
    check(t == 56'h24031502110000, "R8 round up", 64'(t), 64'h24031502110000);
    check(busy == 1'b0, "R8 busy done", 64'(busy), 64'h0);
    // R8: ripple through the year
    load_time(56'h99123104235945);
    wr(4'hD, 4'h6);
    @(negedge clk);
    read_time(t);
    check(t == 56'h00010105000000, "R8 full ripple", 64'(t), 64'h00010105000000);
    // R8: round down
    load_time(56'h24031502102029);
    wr(4'hD, 4'h6);
    check(busy == 1'b0, "R8 no carry busy", 64'(busy), 64'h0);
    @(negedge clk);
    read_time(t);
    check(t == 56'h24031502102000, "R8 round down", 64'(t), 64'h24031502102000);

    // R9 and R11: full clear timing and busy window
    load_time(56'h24031502100000);
    wr(4'hE, 4'h1);
    wr(4'hD, 4'h1);
    repeat (240) @(negedge clk);
    check(busy == 1'b0, "R11 before window", 64'(busy), 64'h0);
    @(negedge clk);
    check(busy == 1'b1, "R11 window start", 64'(busy), 64'h1);
    repeat (14) @(negedge clk);
    read_sec(s); check(s == 8'h00, "R9 full not yet", 64'(s), 64'h00);
    @(negedge clk);
    read_sec(s); check(s == 8'h01, "R9 full exact", 64'(s), 64'h01);
    check(busy == 1'b0, "R11 after step", 64'(busy), 64'h0);

    // R9: partial clear keeps low stages
    wr(4'hD, 4'h1);
    wr(4'hE, 4'h0);
    wr(4'hD, 4'h1);
    repeat (254) @(negedge clk);
    read_sec(s); check(s == 8'h01, "R9 partial not yet", 64'(s), 64'h01);
    @(negedge clk);
    read_sec(s); check(s == 8'h02, "R9 partial early", 64'(s), 64'h02);

    // R10: stop holds one tick, applied on release; schedule kept
    wr(4'hE, 4'h1);
    wr(4'hD, 4'h4);
    load_time(56'h24031502100010);
    wr(4'hD, 4'h5);
    repeat (300) @(negedge clk);
    read_sec(s); check(s == 8'h10, "R10 stop frozen", 64'(s), 64'h10);
    wr(4'hD, 4'h0);
    read_sec(s); check(s == 8'h10, "R10 not before release", 64'(s), 64'h10);
    @(negedge clk);
    read_sec(s); check(s == 8'h11, "R10 pending applied", 64'(s), 64'h11);
    repeat (220) @(negedge clk);
    read_sec(s); check(s == 8'h12, "R10 schedule kept", 64'(s), 64'h12);
    // R10: wait level behaves the same
    wr(4'hD, 4'h9);
    repeat (300) @(negedge clk);
    read_sec(s); check(s == 8'h12, "R10 wait frozen", 64'(s), 64'h12);
    wr(4'hD, 4'h0);
    @(negedge clk);
    read_sec(s); check(s == 8'h13, "R10 wait released", 64'(s), 64'h13);

    // R12: register read-back
    wr(4'hE, 4'h5);
    rd(4'hE, v); check(v == 4'h5, "R12 cfg", 64'(v), 64'h5);
    wr(4'hD, 4'hC);
    rd(4'hD, v); check(v[3:2] == 2'b11, "R12 ctrl levels", 64'(v[3:2]), 64'h3);
    wr(4'hD, 4'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [3:0] A_LEAP_ADDR();
    return 4'hF;
  endfunction
endmodule